// File: doc/BRIEF.md
# Reversible Soft Mute Ramp

This block scales a stereo stream of 16-bit two's complement samples by a gain that glides between silence and unity. A new left/right pair arrives with each sample-rate strobe. Both channels are multiplied by the same gain in the same sample period, and the results are registered.

The gain is an 11-bit counter that runs from 0 (silence) to 1024 (unity). Each strobe moves it one step toward the level the mute request asks for, so a full ramp in either direction lasts 1024 sample periods. The effective request is the OR of two sources: an active-low external mute input and an active-high request from a mode controller. If the request changes while a ramp is under way, the counter turns around at its present value. It never jumps.

After reset the counter sits at zero and the first four strobes are taken up by an initialisation window. During that window the outputs are forced to zero. Two status outputs report the end points of the ramp: fully muted and fully open. A mode controller can use the fully-muted status to apply a settings change while the output is silent.

Top module: `soft_mute_ramp`

## Requirements
- R1: After reset both outputs are zero, `all_muted` is 1 and `all_open` is 0, because the gain starts at 0.
- R2: The first 4 strobes after reset form the initialisation window. Each of them produces a zero output on both channels, whatever the input, and none of them moves the gain.
- R3: After the window, while the effective request is active, each strobe lowers the gain by one until it reaches 0. It then stays at 0.
- R4: After the window, while the effective request is inactive, each strobe raises the gain by one until it reaches 1024. It then stays at 1024.
- R5: When the request changes in the middle of a ramp, the gain carries on from its present value in the new direction. It changes by at most one per strobe.
- R6: On a strobe outside the window, each output becomes floor(sample × gain / 1024), where gain is the value held before that strobe's own step. A gain of 1024 passes the sample through exactly.
- R7: Both channels are scaled with the identical gain value in the same strobe.
- R8: `all_muted` is 1 exactly when the gain is 0, and `all_open` is 1 exactly when the gain is 1024.
- R9: The effective request is active when `mute_req_n` is 0 or `ctl_mute` is 1.
- R10: Without a strobe, the gain and both outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_stb | input | 1 | One-cycle sample-rate strobe |
| mute_req_n | input | 1 | External mute request, active low |
| ctl_mute | input | 1 | Mute request from the mode controller, active high |
| din_l | input | 16 | Left sample, two's complement |
| din_r | input | 16 | Right sample, two's complement |
| dout_l | output | 16 | Scaled left sample |
| dout_r | output | 16 | Scaled right sample |
| all_muted | output | 1 | Gain is 0 |
| all_open | output | 1 | Gain is 1024 |

## Verification
The bench drives ±1024 as input samples, so each output equals plus or minus the gain. This lets it follow the ramp one strobe at a time and catch the following faults:
- A design that skips the initialisation window passes sound in the first four periods.
- A design that advances during the window ends up one or more steps ahead.
- A design that jumps to an end point when the request turns mid-ramp shows a step larger than one.
- A design that wraps at 0 or at 1024 produces a sudden full-scale output.

Odd negative samples at a partial gain reveal rounding toward zero where floor is required. Running the ramp down through the controller request alone exposes a request that ignores one of its two sources.

// File: rtl/smr_pkg.sv
package smr_pkg;

    // number of audio channels carried per strobe
    localparam int SMR_CH = 2;

    // direction chosen for the gain counter on a strobe
    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_DOWN = 2'd1,
        DIR_UP   = 2'd2
    } ramp_dir_e;

endpackage

// File: rtl/smr_gain_ctrl.sv
module smr_gain_ctrl
    import smr_pkg::*;
#(
    parameter int GAIN_SHIFT = 10,
    parameter int INIT_LEN   = 4,
    localparam int GW        = GAIN_SHIFT + 1,
    localparam int IW        = $clog2(INIT_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic          req,
    output logic [GW-1:0] gain,
    output logic          init_busy
);

    localparam logic [GW-1:0] FULL = GW'(1) << GAIN_SHIFT;

    typedef struct packed {
        logic [GW-1:0] gain;
        logic [IW-1:0] icnt;
    } ctl_st_t;

    ctl_st_t   st_d, st_q;
    ramp_dir_e dir;
    logic      busy;

    assign busy = st_q.icnt < IW'(INIT_LEN);

    always_comb begin
        st_d = st_q;
        dir  = DIR_HOLD;
        if (stb && !busy) begin
            if (req && st_q.gain != '0) begin
                dir = DIR_DOWN;
            end else if (!req && st_q.gain != FULL) begin
                dir = DIR_UP;
            end
        end
        if (stb && busy) begin
            st_d.icnt = st_q.icnt + IW'(1);
        end
        case (dir)
            DIR_DOWN: st_d.gain = st_q.gain - GW'(1);
            DIR_UP:   st_d.gain = st_q.gain + GW'(1);
            default:  st_d.gain = st_q.gain;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gain      = st_q.gain;
    assign init_busy = busy;

endmodule

// File: rtl/smr_scale.sv
module smr_scale #(
    parameter int DW         = 16,
    parameter int GAIN_SHIFT = 10,
    localparam int GW        = GAIN_SHIFT + 1,
    localparam int PW        = DW + GW + 1
) (
    input  logic [DW-1:0] sample,
    input  logic [GW-1:0] gain,
    output logic [DW-1:0] scaled
);

    logic signed [PW-1:0] s_ext;
    logic signed [PW-1:0] g_ext;
    logic signed [PW-1:0] prod;

    assign s_ext  = PW'($signed(sample));
    assign g_ext  = PW'({1'b0, gain});
    assign prod   = s_ext * g_ext;
    // arithmetic shift gives floor division by the unity gain
    assign scaled = DW'(prod >>> GAIN_SHIFT);

endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp
    import smr_pkg::*;
#(
    parameter int DW         = 16,
    parameter int GAIN_SHIFT = 10,
    parameter int INIT_LEN   = 4,
    localparam int GW        = GAIN_SHIFT + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_stb,
    input  logic          mute_req_n,
    input  logic          ctl_mute,
    input  logic [DW-1:0] din_l,
    input  logic [DW-1:0] din_r,
    output logic [DW-1:0] dout_l,
    output logic [DW-1:0] dout_r,
    output logic          all_muted,
    output logic          all_open
);

    localparam logic [GW-1:0] FULL = GW'(1) << GAIN_SHIFT;

    typedef struct packed {
        logic [DW-1:0] l;
        logic [DW-1:0] r;
    } out_st_t;

    logic          eff_req;
    logic [GW-1:0] gain;
    logic          init_busy;
    logic [DW-1:0] din_a [SMR_CH];
    logic [DW-1:0] scl_a [SMR_CH];
    out_st_t       out_d, out_q;

    assign eff_req  = ~mute_req_n | ctl_mute;
    assign din_a[0] = din_l;
    assign din_a[1] = din_r;

    smr_gain_ctrl #(
        .GAIN_SHIFT (GAIN_SHIFT),
        .INIT_LEN   (INIT_LEN)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (smp_stb),
        .req       (eff_req),
        .gain      (gain),
        .init_busy (init_busy)
    );

    for (genvar c = 0; c < SMR_CH; c++) begin : g_ch
        smr_scale #(
            .DW         (DW),
            .GAIN_SHIFT (GAIN_SHIFT)
        ) u_scl (
            .sample (din_a[c]),
            .gain   (gain),
            .scaled (scl_a[c])
        );
    end

    always_comb begin
        out_d = out_q;
        if (smp_stb) begin
            out_d.l = init_busy ? '0 : scl_a[0];
            out_d.r = init_busy ? '0 : scl_a[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign dout_l    = out_q.l;
    assign dout_r    = out_q.r;
    assign all_muted = (gain == '0);
    assign all_open  = (gain == FULL);

endmodule

// File: rtl/smr_chk.sv
module smr_chk #(
    parameter int DW         = 16,
    parameter int GAIN_SHIFT = 10,
    localparam int GW        = GAIN_SHIFT + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_stb,
    input logic          eff_req,
    input logic [GW-1:0] gain,
    input logic          init_busy,
    input logic [DW-1:0] dout_l,
    input logic [DW-1:0] dout_r,
    input logic          all_muted,
    input logic          all_open
);

    // R10
    hold_no_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> $stable(gain) && $stable(dout_l) && $stable(dout_r));

    // R5
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> (gain == $past(gain)) || (gain == $past(gain) + GW'(1))
                    || ($past(gain) == gain + GW'(1)));

    // R2
    init_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_busy |-> (dout_l == '0) && (dout_r == '0));

    // R2
    init_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb && init_busy |=> $stable(gain));

    // R8
    status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(all_muted && all_open));

    // R3
    floor_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb && eff_req && !init_busy && all_muted |=> all_muted);

    // R4
    ceil_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb && !eff_req && !init_busy && all_open |=> all_open);

endmodule

bind soft_mute_ramp smr_chk #(
    .DW         (DW),
    .GAIN_SHIFT (GAIN_SHIFT)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_stb   (smp_stb),
    .eff_req   (eff_req),
    .gain      (gain),
    .init_busy (init_busy),
    .dout_l    (dout_l),
    .dout_r    (dout_r),
    .all_muted (all_muted),
    .all_open  (all_open)
);

// File: tb/soft_mute_ramp_tb_top.sv
module soft_mute_ramp_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_stb = 1'b0;
    logic        mute_req_n = 1'b1;
    logic        ctl_mute = 1'b0;
    logic [15:0] din_l = '0;
    logic [15:0] din_r = '0;
    logic [15:0] dout_l, dout_r;
    logic        all_muted, all_open;

    int n_chk  = 0;
    int n_fail = 0;
    int g_exp  = 0;
    int k_init = 0;

    always #2.5 clk = ~clk;

    soft_mute_ramp dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_stb    (smp_stb),
        .mute_req_n (mute_req_n),
        .ctl_mute   (ctl_mute),
        .din_l      (din_l),
        .din_r      (din_r),
        .dout_l     (dout_l),
        .dout_r     (dout_r),
        .all_muted  (all_muted),
        .all_open   (all_open)
    );

    function automatic int mdl(int s, int g);
        return (s * g) >>> 10;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one strobe; model updated, outputs and status compared
    task automatic do_stb(int l, int r, string req);
        int el, er;
        bit rq;
        @(negedge clk);
        din_l = 16'(l); din_r = 16'(r); smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
        rq = !mute_req_n || ctl_mute;
        if (k_init < 4) begin
            el = 0; er = 0; k_init++;
        end else begin
            el = mdl(l, g_exp); er = mdl(r, g_exp);
            if (rq && g_exp > 0) g_exp--;
            else if (!rq && g_exp < 1024) g_exp++;
        end
        chk(int'($signed(dout_l)) == el, {req, " left"}, int'($signed(dout_l)), el);
        chk(int'($signed(dout_r)) == er, {req, " right"}, int'($signed(dout_r)), er);
        chk(all_muted == (g_exp == 0), "R8 muted", all_muted, g_exp == 0);
        chk(all_open == (g_exp == 1024), "R8 open", all_open, g_exp == 1024);
    endtask

    task automatic t_reset;
        chk(dout_l == 0 && dout_r == 0, "R1 outputs", dout_l, 0);
        chk(all_muted == 1'b1, "R1 muted", all_muted, 1);
        chk(all_open == 1'b0, "R1 open", all_open, 0);
    endtask

    task automatic t_init;
        mute_req_n = 1'b1;
        for (int i = 0; i < 4; i++) do_stb(30000, -30000, "R2 window");
        chk(all_muted == 1'b1, "R2 gain frozen", all_muted, 1);
    endtask

    task automatic t_ramp_up;
        for (int i = 0; i < 1030; i++) do_stb(1024, -1024, "R4 R7 up");
        chk(all_open == 1'b1, "R4 at unity", all_open, 1);
    endtask

    task automatic t_pass;
        do_stb(32767, -32768, "R6 pass");
        chk(dout_l == 16'h7fff && dout_r == 16'h8000, "R6 exact", dout_l, 32767);
    endtask

    task automatic t_idle;
        logic [15:0] hl;
        hl = dout_l;
        @(negedge clk); din_l = 16'h1234; din_r = 16'h4321;
        repeat (6) @(negedge clk);
        chk(dout_l == hl, "R10 hold", dout_l, hl);
        chk(all_open == 1'b1, "R10 gain hold", all_open, 1);
    endtask

    task automatic t_reverse;
        mute_req_n = 1'b0;
        for (int i = 0; i < 724; i++) do_stb(1024, -1024, "R3 down");
        do_stb(-32768, 1001, "R6 partial");
        do_stb(-1001, 1001, "R6 floor");
        mute_req_n = 1'b1;
        for (int i = 0; i < 100; i++) do_stb(1024, -1024, "R5 reverse");
        chk(g_exp == 398, "R5 resume", g_exp, 398);
    endtask

    task automatic t_ctl;
        ctl_mute = 1'b1;
        for (int i = 0; i < 410; i++) do_stb(1024, 512, "R9 ctl down");
        chk(all_muted == 1'b1, "R3 R9 floor", all_muted, 1);
        do_stb(32767, -32768, "R3 silent");
        ctl_mute = 1'b0;
        do_stb(1024, -1024, "R9 release");
        do_stb(1024, -1024, "R9 rising");
        chk(dout_l == 16'd1, "R9 one step", dout_l, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_init();
        t_ramp_up();
        t_pass();
        t_idle();
        t_reverse();
        t_ctl();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule